// File: doc/BRIEF.md
# Four-Channel Serial Audio Receiver

This block receives sixteen-bit audio words for four playback channels from a frame-based serial port. The port has a bit clock, a frame clock whose level tells the first half of a frame from the second, and two data lines. The bit clock, frame clock and data lines arrive unsynchronised. The block runs on a faster system clock, so it synchronises these signals and samples the data on each rising edge of the bit clock. It shifts in each word most significant bit first. When a frame is complete, it loads all four channel registers at once and raises a one-cycle strobe.

Two arrangements are supported, and a static configuration bit selects between them. In the paired arrangement, each data line carries a stereo pair: line A carries channels 1 and 2, and line B carries channels 3 and 4. In the single-line arrangement, all four words arrive back to back on line A within one frame. This arrangement needs a 64-bit-clock frame with an even split. A second static input sets the frame length to 32, 48 or 64 bit clocks. Any combination that cannot work is flagged, and no output update happens while it is flagged.

Top module: `quad_pcm_rx`

## Requirements
- R1: While reset is asserted, and after it is released, all four channel outputs are zero and `frame_valid` and `cfg_err` are low. Reset held in the middle of a run clears the channel outputs.
- R2: In the paired arrangement (`cfg_one_line`=0), the word on `sd_a` while `fclk` is low goes to `ch1`. The word on `sd_a` while `fclk` is high goes to `ch2`. The words on `sd_b` in the low half and the high half go to `ch3` and `ch4`.
- R3: In the single-line arrangement (`cfg_one_line`=1), the low half of the frame carries `ch1` and then `ch2` on `sd_a`. The high half carries `ch3` and then `ch4` on `sd_a`. Each word is 16 consecutive bits.
- R4: Each word is 16 bits, sent most significant bit first. The first bit of a half frame is the bit sampled on the first rising `bclk` edge at which `fclk` has changed level.
- R5: In the paired arrangement with 48 or 64 bit clocks per frame, the bits after the sixteenth in a half frame do not affect any output.
- R6: In the single-line arrangement, `sd_b` does not affect any output.
- R7: A frame runs from a falling `fclk` (low half) through the high half. It is delivered when the next falling `fclk` is seen. All four outputs change together, in the same cycle as a `frame_valid` pulse one system clock long, and at no other time.
- R8: `cfg_bpf` encodes frame length as 0 for 32, 1 for 48, 2 for 64, and 3 as reserved. `cfg_err` goes high when `cfg_bpf`=3, or when `cfg_one_line`=1 with a frame length other than 64. While it is high, no `frame_valid` occurs and the outputs hold.
- R9: A frame is delivered only if both of its halves hold exactly half the configured number of bit clocks. A frame with any other half length is discarded. A correct frame that follows it is delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `bclk` |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| cfg_one_line | input | 1 | 1 selects the single-line arrangement, 0 the paired one |
| cfg_bpf | input | 2 | Bit clocks per frame: 0=32, 1=48, 2=64, 3=reserved |
| bclk | input | 1 | Serial bit clock; data sampled on its rising edge |
| fclk | input | 1 | Frame clock; low = first half, high = second half |
| sd_a | input | 1 | Serial data line A |
| sd_b | input | 1 | Serial data line B (paired arrangement only) |
| ch1 | output | 16 | Channel 1 sample |
| ch2 | output | 16 | Channel 2 sample |
| ch3 | output | 16 | Channel 3 sample |
| ch4 | output | 16 | Channel 4 sample |
| frame_valid | output | 1 | One-cycle strobe when the four outputs load |
| cfg_err | output | 1 | Configuration cannot be served; updates suppressed |

## Verification
A bit counter that is off by one shifts every word by a bit. This shows up as a doubled or halved sample value on the first delivered frame. A wrong half-length check shows up a frame later, as a missing or extra `frame_valid`. A swapped slot in the pending bank, or a swapped routing slot, puts a correct word on the wrong channel at the first delivery. Each vector therefore uses four distinct words, so that no channel can match by accident. Bad configurations and mismatched frames are checked by counting strobes across a whole frame plus its delivery edge, and by confirming that the outputs still hold the earlier frame.

// File: rtl/qsr_pkg.sv
package qsr_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 6;
  localparam int NSLOT  = 3;
  localparam int NCH    = 4;

  localparam logic [1:0] BPF_32  = 2'd0;
  localparam logic [1:0] BPF_48  = 2'd1;
  localparam logic [1:0] BPF_64  = 2'd2;
  localparam logic [1:0] BPF_RSV = 2'd3;

  // bit clocks in one half frame for a frame-length code
  function automatic logic [CNT_W-1:0] half_bits(input logic [1:0] sel);
    case (sel)
      BPF_32:  half_bits = CNT_W'(16);
      BPF_48:  half_bits = CNT_W'(24);
      default: half_bits = CNT_W'(32);
    endcase
  endfunction

  // whether the configuration can be served
  function automatic logic cfg_legal(input logic one_line, input logic [1:0] sel);
    if (sel == BPF_RSV)
      cfg_legal = 1'b0;
    else if (one_line)
      cfg_legal = (sel == BPF_64);
    else
      cfg_legal = 1'b1;
  endfunction

  // whether a bit index falls in a word slot starting at lo
  function automatic logic in_slot(input logic [CNT_W-1:0] idx, input int lo, input int width);
    in_slot = (int'(idx) >= lo) && (int'(idx) < lo + width);
  endfunction
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl import qsr_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_evt,
  input  logic             fclk_bit,
  input  logic [CNT_W-1:0] half_len,
  output logic [CNT_W-1:0] bit_idx,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             frame_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic fclk_last;
  logic level_chg;
  logic half_full;
  logic started;
  logic low_ok;

  assign level_chg = bit_evt && (fclk_bit != fclk_last);
  assign rise_evt  = level_chg && fclk_bit;
  assign fall_evt  = level_chg && !fclk_bit;
  assign half_full = (bit_cnt == half_len);
  assign bit_idx   = level_chg ? '0 : bit_cnt;
  assign frame_ok  = fall_evt && started && low_ok && half_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fclk_last <= 1'b0;
      bit_cnt   <= '0;
    end else if (bit_evt) begin
      fclk_last <= fclk_bit;
      if (level_chg)
        bit_cnt <= CNT_W'(1);
      else if (bit_cnt != CNT_MAX)
        bit_cnt <= bit_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      low_ok  <= 1'b0;
    end else begin
      if (fall_evt)
        started <= 1'b1;
      if (rise_evt)
        low_ok <= started && half_full;
    end
  end
endmodule

// File: rtl/word_shifter.sv
module word_shifter import qsr_pkg::*; #(
  parameter int W  = WORD_W,
  parameter int LO = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_evt,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic             din,
  output logic [W-1:0]     word
);
  logic take;

  assign take = bit_evt && in_slot(bit_idx, LO, W);

  always_ff @(posedge clk) begin
    if (!rst_n)
      word <= '0;
    else if (take)
      word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/slot_router.sv
module slot_router import qsr_pkg::*; #(
  parameter int W = WORD_W
) (
  input  logic                    one_line,
  input  logic [NSLOT-1:0][W-1:0] pend,
  input  logic [NSLOT-1:0][W-1:0] cur,
  output logic [NCH-1:0][W-1:0]   chans
);
  // slot 0: line A first word, slot 1: line A second word, slot 2: line B
  always_comb begin
    if (one_line) begin
      chans[0] = pend[0];
      chans[1] = pend[1];
      chans[2] = cur[0];
      chans[3] = cur[1];
    end else begin
      chans[0] = pend[0];
      chans[1] = cur[0];
      chans[2] = pend[2];
      chans[3] = cur[2];
    end
  end
endmodule

// File: rtl/quad_pcm_rx.sv
module quad_pcm_rx import qsr_pkg::*; #(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_one_line,
  input  logic [1:0]   cfg_bpf,
  input  logic         bclk,
  input  logic         fclk,
  input  logic         sd_a,
  input  logic         sd_b,
  output logic [W-1:0] ch1,
  output logic [W-1:0] ch2,
  output logic [W-1:0] ch3,
  output logic [W-1:0] ch4,
  output logic         frame_valid,
  output logic         cfg_err
);
  localparam int NRAW = 4;

  logic [NRAW-1:0] raw_in;
  logic [NRAW-1:0] synced;
  logic            bclk_s, fclk_s, sda_s, sdb_s;
  logic            bclk_d;
  logic            bit_evt;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] bit_idx;
  logic [CNT_W-1:0] bit_cnt;
  logic            rise_evt, fall_evt, frame_ok;
  logic [NSLOT-1:0][W-1:0] cur_word;
  logic [NSLOT-1:0][W-1:0] pend_word;
  logic [NCH-1:0][W-1:0]   routed;
  logic [NCH-1:0][W-1:0]   ch_q;
  logic [NCH*W-1:0]        ch_bus;

  assign raw_in = {bclk, fclk, sd_a, sd_b};

  sync2 #(.W(NRAW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (synced)
  );

  assign {bclk_s, fclk_s, sda_s, sdb_s} = synced;

  always_ff @(posedge clk) begin
    if (!rst_n)
      bclk_d <= 1'b0;
    else
      bclk_d <= bclk_s;
  end

  assign bit_evt  = bclk_s && !bclk_d;
  assign half_len = half_bits(cfg_bpf);

  frame_ctrl u_fc (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_evt  (bit_evt),
    .fclk_bit (fclk_s),
    .half_len (half_len),
    .bit_idx  (bit_idx),
    .bit_cnt  (bit_cnt),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .frame_ok (frame_ok)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int SLOT_LO = (g == 1) ? W : 0;

    word_shifter #(.W(W), .LO(SLOT_LO)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_evt (bit_evt),
      .bit_idx (bit_idx),
      .din     ((g == NSLOT - 1) ? sdb_s : sda_s),
      .word    (cur_word[g])
    );

    // low-half words are parked when the high half begins
    always_ff @(posedge clk) begin
      if (!rst_n)
        pend_word[g] <= '0;
      else if (rise_evt)
        pend_word[g] <= cur_word[g];
    end
  end

  slot_router #(.W(W)) u_route (
    .one_line (cfg_one_line),
    .pend     (pend_word),
    .cur      (cur_word),
    .chans    (routed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_err <= 1'b0;
    else
      cfg_err <= !cfg_legal(cfg_one_line, cfg_bpf);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q        <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (frame_ok && !cfg_err) begin
        ch_q        <= routed;
        frame_valid <= 1'b1;
      end
    end
  end

  assign ch1    = ch_q[0];
  assign ch2    = ch_q[1];
  assign ch3    = ch_q[2];
  assign ch4    = ch_q[3];
  assign ch_bus = {ch1, ch2, ch3, ch4};
endmodule

// File: rtl/quad_pcm_rx_chk.sv
module quad_pcm_rx_chk import qsr_pkg::*; #(
  parameter int W = WORD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic             cfg_err,
  input logic             fall_evt,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [NCH*W-1:0] ch_bus
);
  // R7: the strobe lasts one system clock
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R7: outputs move only together with the strobe
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ch_bus == $past(ch_bus));

  // R7: delivery follows a detected frame start
  a_r7_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(fall_evt));

  // R8: a flagged configuration blocks delivery
  a_r8_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> !frame_valid);

  // R4 R9: the half-frame bit count restarts at each level change
  a_r9_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> bit_cnt == CNT_W'(1));
endmodule

bind quad_pcm_rx quad_pcm_rx_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_valid (frame_valid),
  .cfg_err     (cfg_err),
  .fall_evt    (fall_evt),
  .bit_cnt     (bit_cnt),
  .ch_bus      (ch_bus)
);

// File: tb/quad_pcm_rx_test.sv
`timescale 1ns/1ps
module quad_pcm_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_one_line = 1'b0;
  logic [1:0]  cfg_bpf = 2'd0;
  logic        bclk = 1'b0;
  logic        fclk = 1'b1;
  logic        sd_a = 1'b0;
  logic        sd_b = 1'b0;
  logic [15:0] ch1, ch2, ch3, ch4;
  logic        frame_valid, cfg_err;

  int checks = 0;
  int errors = 0;
  int ncap = 0;
  int wide = 0;
  logic [63:0] cap;
  logic        last_valid = 1'b0;

  always #2 clk = ~clk;

  quad_pcm_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_one_line(cfg_one_line), .cfg_bpf(cfg_bpf),
    .bclk(bclk), .fclk(fclk), .sd_a(sd_a), .sd_b(sd_b),
    .ch1(ch1), .ch2(ch2), .ch3(ch3), .ch4(ch4),
    .frame_valid(frame_valid), .cfg_err(cfg_err)
  );

  // {one_line, bpf code, ch1, ch2, ch3, ch4}
  localparam logic [66:0] VEC [0:4] = '{
    {1'b0, 2'd0, 16'h1234, 16'hABCD, 16'h8001, 16'h7FFE},
    {1'b0, 2'd1, 16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A},
    {1'b0, 2'd2, 16'h0F0F, 16'hF0F0, 16'h1357, 16'h9BDF},
    {1'b1, 2'd2, 16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D},
    {1'b1, 2'd2, 16'h0001, 16'h8000, 16'hFFFE, 16'h7FFF}
  };

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      cap  = {ch1, ch2, ch3, ch4};
      ncap = ncap + 1;
      if (last_valid) wide = wide + 1;
    end
    last_valid = frame_valid;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic f, input logic a, input logic b);
    @(negedge clk);
    bclk = 1'b0; fclk = f; sd_a = a; sd_b = b;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one half frame; x/y go on line A, z on line B
  task automatic send_half(input logic f, input int nbits, input logic one,
                           input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    for (int i = 0; i < nbits; i++) begin
      logic a, b;
      logic junk;
      junk = ~i[0];
      if (one) begin
        a = (i < 16) ? x[15-i] : ((i < 32) ? y[31-i] : junk);
        b = i[1] ^ i[0];
      end else begin
        a = (i < 16) ? x[15-i] : junk;
        b = (i < 16) ? z[15-i] : junk;
      end
      drive_bit(f, a, b);
    end
  endtask

  task automatic send_frame(input int nbits, input logic one,
                            input logic [15:0] w1, input logic [15:0] w2,
                            input logic [15:0] w3, input logic [15:0] w4);
    if (one) begin
      send_half(1'b0, nbits, 1'b1, w1, w2, 16'h0);
      send_half(1'b1, nbits, 1'b1, w3, w4, 16'h0);
    end else begin
      send_half(1'b0, nbits, 1'b0, w1, 16'h0, w3);
      send_half(1'b1, nbits, 1'b0, w2, 16'h0, w4);
    end
  endtask

  task automatic preamble();
    for (int i = 0; i < 3; i++) drive_bit(1'b1, 1'b1, 1'b0);
  endtask

  task automatic flush();
    drive_bit(1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
  endtask

  function automatic int half_of(input logic [1:0] code);
    return (code == 2'd0) ? 16 : ((code == 2'd1) ? 24 : 32);
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] keep;
    repeat (5) @(negedge clk);
    // R1: state while in reset
    chk("R1 outputs in reset", {ch1, ch2}, 32'h0);
    chk("R1 valid/err in reset", {30'h0, frame_valid, cfg_err}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs after reset", {ch3, ch4}, 32'h0);

    // table of vectors: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 5; v++) begin
      logic one;
      logic [1:0] code;
      logic [15:0] w1, w2, w3, w4;
      {one, code, w1, w2, w3, w4} = VEC[v];
      cfg_one_line = one;
      cfg_bpf = code;
      repeat (4) @(negedge clk);
      ncap = 0; wide = 0;
      preamble();
      send_frame(half_of(code), one, w1, w2, w3, w4);
      flush();
      chk(one ? "R3 R7 one strobe per frame" : "R2 R7 one strobe per frame", ncap, 1);
      chk("R7 strobe width", wide, 0);
      chk(one ? "R3 R4 ch1" : "R2 R4 ch1", cap[63:48], w1);
      chk(one ? "R3 R6 ch2" : "R2 R5 ch2", cap[47:32], w2);
      chk(one ? "R3 R6 ch3" : "R2 R5 ch3", cap[31:16], w3);
      chk(one ? "R3 R6 ch4" : "R2 R5 ch4", cap[15:0], w4);
    end
    keep = {ch1, ch2, ch3, ch4};

    // R8: single line with a 32-clock frame
    cfg_one_line = 1'b1; cfg_bpf = 2'd0;
    repeat (4) @(negedge clk);
    chk("R8 flag one-line short frame", cfg_err, 1);
    ncap = 0;
    preamble();
    send_frame(16, 1'b1, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    flush();
    chk("R8 no strobe while flagged", ncap, 0);
    chk("R8 outputs hold", {ch1, ch4}, {keep[63:48], keep[15:0]});

    // R8: reserved code
    cfg_one_line = 1'b0; cfg_bpf = 2'd3;
    repeat (4) @(negedge clk);
    chk("R8 flag reserved code", cfg_err, 1);
    cfg_bpf = 2'd0;
    repeat (4) @(negedge clk);
    chk("R8 flag clears", cfg_err, 0);

    // R9: wrong half length is dropped, following good frame delivered
    ncap = 0;
    preamble();
    send_frame(24, 1'b0, 16'h5555, 16'h6666, 16'h7777, 16'h8888);
    send_frame(16, 1'b0, 16'h9999, 16'hAAAA, 16'hBBBB, 16'hCCCC);
    flush();
    chk("R9 only good frame delivered", ncap, 1);
    chk("R9 good frame ch1 ch4", {ch1, ch4}, 32'h9999CCCC);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset mid-run", {ch2, ch3}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule